// File: doc/BRIEF.md
# Raster Timing Generator with Tiled Pixel Fetch

This block produces the scan timing for a progressive display: a horizontal and a vertical position counter, a blank signal, and horizontal and vertical sync pulses. The active sizes, porches and sync widths of both axes are set at elaboration, so any resolution can be built from the same code. The defaults give 800x600 active pixels, which runs at 60 Hz from a 40 MHz pixel clock, with both syncs active high. Each sync has its own polarity parameter, and each of the three colour channels has a width parameter.

Colour is not streamed in. For each active pixel the block raises a request together with the image column and row it wants. The provider answers in the same cycle with a valid flag and the colour. The image held by the provider can be smaller than the active area. The block then wraps the column at a runtime width and the row at a runtime height, which tiles the picture across the screen. Position decoding is registered one stage after the counters, and colour and timing are registered once more at the outputs. This keeps the logic depth between flops short at high pixel rates. An enable input holds the raster at the start of a frame while it is low.

Top module: `raster_gen`

## Requirements
- R1: Let a pixel have column h and row v. That pixel is active when h < H_ACTIVE and v < V_ACTIVE, and vidBlank is low exactly for active pixels. Take the first clock edge that samples enable high after it was low. The pixel (0,0) appears at the outputs after the fourth edge counted from that one. Each following clock delivers the next pixel in scan order, where a line is H_ACTIVE+H_FRONT+H_SYNC+H_BACK pixels long and a frame is V_ACTIVE+V_FRONT+V_SYNC+V_BACK lines long.
- R2: vidHsync equals HSYNC_POL while H_ACTIVE+H_FRONT <= h < H_ACTIVE+H_FRONT+H_SYNC, and equals the inverse of HSYNC_POL at every other column.
- R3: vidVsync equals VSYNC_POL on every pixel of the rows where V_ACTIVE+V_FRONT <= v < V_ACTIVE+V_FRONT+V_SYNC, and equals the inverse of VSYNC_POL on all other rows.
- R4: vidRed, vidGreen and vidBlue are all zero in every cycle in which vidBlank is high.
- R5: pixReq is high in exactly one cycle for each active pixel. That cycle is the one just before the pixel appears at the outputs, and pixReq is low at all other times.
- R6: While pixReq is high, imgX equals h mod imgWidth and imgY equals v mod imgHeight, for the pixel being requested.
- R7: An active pixel shows the colour presented on pixRed, pixGreen and pixBlue during its request cycle, provided pixValid is high in that cycle. If pixValid is low in that cycle, the pixel is black (all channels zero).
- R8: While enable is low, the raster is held at pixel (0,0). From the fourth edge that samples enable low onward, vidBlank is high, both syncs are at their inactive levels, the colour is zero and pixReq is low. When enable rises again, the frame starts at pixel (0,0), as R1 describes.
- R9: While rst is high, vidBlank is high, both syncs are inactive, the colour is zero and pixReq is low.
- R10: A value of 0 on imgWidth or imgHeight acts as 1, so the matching coordinate stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run the raster; low holds it at frame start |
| imgWidth | input | IMG_W | Runtime image width for column wrap |
| imgHeight | input | IMG_W | Runtime image height for row wrap |
| pixReq | output | 1 | Request for one pixel colour |
| imgX | output | IMG_W | Image column of the requested pixel |
| imgY | output | IMG_W | Image row of the requested pixel |
| pixValid | input | 1 | Provider colour is valid in the request cycle |
| pixRed | input | COLOR_W | Provider red |
| pixGreen | input | COLOR_W | Provider green |
| pixBlue | input | COLOR_W | Provider blue |
| vidRed | output | COLOR_W | Registered red output |
| vidGreen | output | COLOR_W | Registered green output |
| vidBlue | output | COLOR_W | Registered blue output |
| vidHsync | output | 1 | Horizontal sync |
| vidVsync | output | 1 | Vertical sync |
| vidBlank | output | 1 | High outside the active area |

## Verification
A position counter that is off by one moves the blank and sync edges by one pixel, or by one whole line, against arithmetic expectations. This shows on the first affected line of the first frame after enable rises. A wrong wrap counter produces a request whose imgX or imgY differs from the column or row modulo the runtime size. It also produces a colour that does not match the provider function, so it shows in the first tiled line, and in the second line for a row fault. A fault in the pipeline alignment or in the hold logic separates pixReq from the unblanked cycle that follows it. It can also leave pixels after enable drops, or start the next frame at the wrong pixel. All of these appear within a few cycles of the event.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Strobes the counter stage hands to the datapath, one set per pixel clock.
  typedef struct packed {
    logic active;    // pixel lies inside the visible area
    logic hsync;     // column lies in the horizontal sync window
    logic vsync;     // row lies in the vertical sync window
    logic firstCol;  // column 0 of a visible row
    logic firstRow;  // row 0 of the frame
  } rasterStrobe_t;

  localparam rasterStrobe_t IDLE_STROBE = '0;

endpackage

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import raster_pkg::*;
#(
  parameter int H_ACTIVE = 800,
  parameter int H_FRONT  = 40,
  parameter int H_SYNC   = 128,
  parameter int H_BACK   = 88,
  parameter int V_ACTIVE = 600,
  parameter int V_FRONT  = 1,
  parameter int V_SYNC   = 4,
  parameter int V_BACK   = 23
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  output rasterStrobe_t strobe
);

  localparam int H_TOTAL     = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL     = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int HCW         = $clog2(H_TOTAL);
  localparam int VCW         = $clog2(V_TOTAL);
  localparam int H_SYNC_FROM = H_ACTIVE + H_FRONT;
  localparam int H_SYNC_TO   = H_SYNC_FROM + H_SYNC;
  localparam int V_SYNC_FROM = V_ACTIVE + V_FRONT;
  localparam int V_SYNC_TO   = V_SYNC_FROM + V_SYNC;

  logic [HCW-1:0] hCnt;
  logic [VCW-1:0] vCnt;
  logic           cntLive;
  logic           lastCol;
  logic           lastRow;
  rasterStrobe_t  decoded;

  assign lastCol = int'(hCnt) == H_TOTAL - 1;
  assign lastRow = int'(vCnt) == V_TOTAL - 1;

  // Position counters: held at frame start while stopped, the first live
  // cycle presents pixel (0,0) before any advance.
  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      hCnt    <= '0;
      vCnt    <= '0;
      cntLive <= 1'b0;
    end else begin
      cntLive <= 1'b1;
      if (cntLive) begin
        if (lastCol) begin
          hCnt <= '0;
          vCnt <= lastRow ? '0 : vCnt + VCW'(1);
        end else begin
          hCnt <= hCnt + HCW'(1);
        end
      end
    end
  end

  // Window compares, registered below so they do not chain into the datapath.
  always_comb begin
    decoded.active   = (int'(hCnt) < H_ACTIVE) && (int'(vCnt) < V_ACTIVE);
    decoded.hsync    = (int'(hCnt) >= H_SYNC_FROM) && (int'(hCnt) < H_SYNC_TO);
    decoded.vsync    = (int'(vCnt) >= V_SYNC_FROM) && (int'(vCnt) < V_SYNC_TO);
    decoded.firstCol = (hCnt == '0) && (int'(vCnt) < V_ACTIVE);
    decoded.firstRow = (vCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe <= IDLE_STROBE;
    end else begin
      strobe <= cntLive ? decoded : IDLE_STROBE;
    end
  end

endmodule

// File: rtl/raster_wrap.sv
module raster_wrap #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] value
);

  logic [W:0] nextUp;

  assign nextUp = {1'b0, value} + (W+1)'(1);

  // Modular counter: restart wins over step; a limit of 0 behaves as 1.
  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else if (restart) begin
      value <= '0;
    end else if (step) begin
      value <= (nextUp >= {1'b0, limit}) ? '0 : nextUp[W-1:0];
    end
  end

endmodule

// File: rtl/raster_dp.sv
module raster_dp
  import raster_pkg::*;
#(
  parameter int   COLOR_W   = 8,
  parameter int   IMG_W     = 10,
  parameter logic HSYNC_POL = 1'b1,
  parameter logic VSYNC_POL = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  rasterStrobe_t      strobe,
  input  logic [IMG_W-1:0]   imgWidth,
  input  logic [IMG_W-1:0]   imgHeight,
  output logic               pixReq,
  output logic [IMG_W-1:0]   imgX,
  output logic [IMG_W-1:0]   imgY,
  input  logic               pixValid,
  input  logic [COLOR_W-1:0] pixRed,
  input  logic [COLOR_W-1:0] pixGreen,
  input  logic [COLOR_W-1:0] pixBlue,
  output logic [COLOR_W-1:0] vidRed,
  output logic [COLOR_W-1:0] vidGreen,
  output logic [COLOR_W-1:0] vidBlue,
  output logic               vidHsync,
  output logic               vidVsync,
  output logic               vidBlank
);

  rasterStrobe_t reqStage;
  logic          takeColor;

  // Request stage: timing strobes travel alongside the request.
  always_ff @(posedge clk) begin
    if (rst) begin
      reqStage <= IDLE_STROBE;
    end else begin
      reqStage <= strobe;
    end
  end

  assign pixReq = reqStage.active;

  raster_wrap #(.W(IMG_W)) u_colWrap (
    .clk     (clk),
    .rst     (rst),
    .restart (strobe.active && strobe.firstCol),
    .step    (strobe.active),
    .limit   (imgWidth),
    .value   (imgX)
  );

  raster_wrap #(.W(IMG_W)) u_rowWrap (
    .clk     (clk),
    .rst     (rst),
    .restart (strobe.active && strobe.firstCol && strobe.firstRow),
    .step    (strobe.active && strobe.firstCol),
    .limit   (imgHeight),
    .value   (imgY)
  );

  assign takeColor = reqStage.active && pixValid;

  // Output stage: colour captured in the request cycle, black otherwise.
  always_ff @(posedge clk) begin
    if (rst) begin
      vidRed   <= '0;
      vidGreen <= '0;
      vidBlue  <= '0;
      vidHsync <= ~HSYNC_POL;
      vidVsync <= ~VSYNC_POL;
      vidBlank <= 1'b1;
    end else begin
      vidRed   <= takeColor ? pixRed   : '0;
      vidGreen <= takeColor ? pixGreen : '0;
      vidBlue  <= takeColor ? pixBlue  : '0;
      vidHsync <= reqStage.hsync ? HSYNC_POL : ~HSYNC_POL;
      vidVsync <= reqStage.vsync ? VSYNC_POL : ~VSYNC_POL;
      vidBlank <= ~reqStage.active;
    end
  end

endmodule

// File: rtl/raster_gen.sv
module raster_gen
  import raster_pkg::*;
#(
  parameter int   H_ACTIVE  = 800,
  parameter int   H_FRONT   = 40,
  parameter int   H_SYNC    = 128,
  parameter int   H_BACK    = 88,
  parameter int   V_ACTIVE  = 600,
  parameter int   V_FRONT   = 1,
  parameter int   V_SYNC    = 4,
  parameter int   V_BACK    = 23,
  parameter int   COLOR_W   = 8,
  parameter int   IMG_W     = 10,
  parameter logic HSYNC_POL = 1'b1,
  parameter logic VSYNC_POL = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic [IMG_W-1:0]   imgWidth,
  input  logic [IMG_W-1:0]   imgHeight,
  output logic               pixReq,
  output logic [IMG_W-1:0]   imgX,
  output logic [IMG_W-1:0]   imgY,
  input  logic               pixValid,
  input  logic [COLOR_W-1:0] pixRed,
  input  logic [COLOR_W-1:0] pixGreen,
  input  logic [COLOR_W-1:0] pixBlue,
  output logic [COLOR_W-1:0] vidRed,
  output logic [COLOR_W-1:0] vidGreen,
  output logic [COLOR_W-1:0] vidBlue,
  output logic               vidHsync,
  output logic               vidVsync,
  output logic               vidBlank
);

  rasterStrobe_t strobe;

  raster_ctrl #(
    .H_ACTIVE (H_ACTIVE), .H_FRONT (H_FRONT), .H_SYNC (H_SYNC), .H_BACK (H_BACK),
    .V_ACTIVE (V_ACTIVE), .V_FRONT (V_FRONT), .V_SYNC (V_SYNC), .V_BACK (V_BACK)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .strobe (strobe)
  );

  raster_dp #(
    .COLOR_W (COLOR_W), .IMG_W (IMG_W),
    .HSYNC_POL (HSYNC_POL), .VSYNC_POL (VSYNC_POL)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .imgWidth  (imgWidth),
    .imgHeight (imgHeight),
    .pixReq    (pixReq),
    .imgX      (imgX),
    .imgY      (imgY),
    .pixValid  (pixValid),
    .pixRed    (pixRed),
    .pixGreen  (pixGreen),
    .pixBlue   (pixBlue),
    .vidRed    (vidRed),
    .vidGreen  (vidGreen),
    .vidBlue   (vidBlue),
    .vidHsync  (vidHsync),
    .vidVsync  (vidVsync),
    .vidBlank  (vidBlank)
  );

endmodule

// File: rtl/raster_gen_chk.sv
module raster_gen_chk #(
  parameter int   COLOR_W   = 8,
  parameter int   IMG_W     = 10,
  parameter logic HSYNC_POL = 1'b1,
  parameter logic VSYNC_POL = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic               enable,
  input logic [IMG_W-1:0]   imgWidth,
  input logic               pixReq,
  input logic [IMG_W-1:0]   imgX,
  input logic [COLOR_W-1:0] vidRed,
  input logic [COLOR_W-1:0] vidGreen,
  input logic [COLOR_W-1:0] vidBlue,
  input logic               vidHsync,
  input logic               vidVsync,
  input logic               vidBlank
);

  // R4: blanked cycles carry no colour
  a_r4_black_in_blank: assert property (@(posedge clk) disable iff (rst)
    vidBlank |-> (vidRed == '0 && vidGreen == '0 && vidBlue == '0));

  // R2: horizontal sync pulse lies outside the visible area
  a_r2_hsync_in_blank: assert property (@(posedge clk) disable iff (rst)
    (vidHsync == HSYNC_POL) |-> vidBlank);

  // R3: vertical sync pulse lies outside the visible area
  a_r3_vsync_in_blank: assert property (@(posedge clk) disable iff (rst)
    (vidVsync == VSYNC_POL) |-> vidBlank);

  // R5: each request is followed by a visible pixel
  a_r5_req_leads_pixel: assert property (@(posedge clk) disable iff (rst)
    pixReq |=> !vidBlank);

  // R5: no visible pixel without a request one cycle earlier
  a_r5_no_pixel_without_req: assert property (@(posedge clk) disable iff (rst)
    !pixReq |=> vidBlank);

  // R6: requested column stays inside the runtime width
  a_r6_column_in_image: assert property (@(posedge clk) disable iff (rst)
    (pixReq && imgWidth != '0 && $stable(imgWidth)) |-> (imgX < imgWidth));

  // R8: a stopped raster goes idle
  a_r8_idle_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!enable && !$past(enable) && !$past(enable, 2) && !$past(enable, 3))
    |=> (vidBlank && !pixReq && vidHsync == ~HSYNC_POL && vidVsync == ~VSYNC_POL));

endmodule

bind raster_gen raster_gen_chk #(
  .COLOR_W (COLOR_W), .IMG_W (IMG_W),
  .HSYNC_POL (HSYNC_POL), .VSYNC_POL (VSYNC_POL)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .enable   (enable),
  .imgWidth (imgWidth),
  .pixReq   (pixReq),
  .imgX     (imgX),
  .vidRed   (vidRed),
  .vidGreen (vidGreen),
  .vidBlue  (vidBlue),
  .vidHsync (vidHsync),
  .vidVsync (vidVsync),
  .vidBlank (vidBlank)
);

// File: tb/raster_gen_tb.sv
`timescale 1ns/1ps
module raster_gen_tb;

  localparam int   HA = 8, HF = 2, HS = 3, HB = 2;
  localparam int   VA = 5, VF = 1, VS = 2, VB = 1;
  localparam int   HT = HA + HF + HS + HB;
  localparam int   VT = VA + VF + VS + VB;
  localparam int   CW = 6;
  localparam int   IW = 4;
  localparam logic HPOL = 1'b0;
  localparam logic VPOL = 1'b1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic [IW-1:0] imgWidth = '0;
  logic [IW-1:0] imgHeight = '0;
  logic          pixReq;
  logic [IW-1:0] imgX, imgY;
  logic          pixValid;
  logic [CW-1:0] pixRed, pixGreen, pixBlue;
  logic [CW-1:0] vidRed, vidGreen, vidBlue;
  logic          vidHsync, vidVsync, vidBlank;

  int  vectors = 0;
  int  misses  = 0;
  bit  dropMode = 1'b0;
  int  curW = 1, curH = 1;

  always #10 clk = ~clk;

  raster_gen #(
    .H_ACTIVE (HA), .H_FRONT (HF), .H_SYNC (HS), .H_BACK (HB),
    .V_ACTIVE (VA), .V_FRONT (VF), .V_SYNC (VS), .V_BACK (VB),
    .COLOR_W (CW), .IMG_W (IW), .HSYNC_POL (HPOL), .VSYNC_POL (VPOL)
  ) u_dut (
    .clk (clk), .rst (rst), .enable (enable),
    .imgWidth (imgWidth), .imgHeight (imgHeight),
    .pixReq (pixReq), .imgX (imgX), .imgY (imgY),
    .pixValid (pixValid), .pixRed (pixRed), .pixGreen (pixGreen), .pixBlue (pixBlue),
    .vidRed (vidRed), .vidGreen (vidGreen), .vidBlue (vidBlue),
    .vidHsync (vidHsync), .vidVsync (vidVsync), .vidBlank (vidBlank)
  );

  function automatic int fR(int x, int y); return (x * 3 + y) % 64; endfunction
  function automatic int fG(int x, int y); return (y * 5 + x + 1) % 64; endfunction
  function automatic int fB(int x, int y); return (x ^ (y << 2)) % 64; endfunction
  function automatic bit dropAt(int x, int y); return dropMode && ((x + 2 * y) % 4 == 3); endfunction

  // Provider: answers in the request cycle, some pixels withheld in drop mode.
  assign pixValid = pixReq && !dropAt(int'(imgX), int'(imgY));
  assign pixRed   = CW'(fR(int'(imgX), int'(imgY)));
  assign pixGreen = CW'(fG(int'(imgX), int'(imgY)));
  assign pixBlue  = CW'(fB(int'(imgX), int'(imgY)));

  // Output check for scan pixel n; n < 0 means the idle state (R8, R9).
  task automatic checkOut(int n, string tag);
    int h, v, x, y, eR, eG, eB;
    bit act;
    logic eBl, eHs, eVs;
    if (n < 0) begin
      act = 0; eHs = ~HPOL; eVs = ~VPOL;
    end else begin
      h = n % HT; v = (n / HT) % VT;
      act = (h < HA) && (v < VA);
      eHs = (h >= HA + HF && h < HA + HF + HS) ? HPOL : ~HPOL;  // R2
      eVs = (v >= VA + VF && v < VA + VF + VS) ? VPOL : ~VPOL;  // R3
    end
    eBl = ~act;  // R1
    eR = 0; eG = 0; eB = 0;  // R4
    if (act) begin
      x = h % curW; y = v % curH;
      if (!dropAt(x, y)) begin eR = fR(x, y); eG = fG(x, y); eB = fB(x, y); end  // R7
    end
    vectors++;
    if (vidBlank !== eBl || vidHsync !== eHs || vidVsync !== eVs ||
        vidRed !== CW'(eR) || vidGreen !== CW'(eG) || vidBlue !== CW'(eB)) begin
      misses++;
      $display("FAIL %s pixel %0d: blank/hs/vs=%b%b%b rgb=%0d,%0d,%0d expected %b%b%b rgb=%0d,%0d,%0d",
               tag, n, vidBlank, vidHsync, vidVsync, vidRed, vidGreen, vidBlue,
               eBl, eHs, eVs, eR, eG, eB);
    end
  endtask

  // Request check for scan pixel n (R5, R6); n < 0 means no request.
  task automatic checkReq(int n, string tag);
    int h, v, eX, eY;
    bit act;
    act = 0; eX = 0; eY = 0;
    if (n >= 0) begin
      h = n % HT; v = (n / HT) % VT;
      act = (h < HA) && (v < VA);
      eX = h % curW; eY = v % curH;
    end
    vectors++;
    if (pixReq !== act || (act && (int'(imgX) != eX || int'(imgY) != eY))) begin
      misses++;
      $display("FAIL %s request %0d: req=%b x=%0d y=%0d expected req=%b x=%0d y=%0d",
               tag, n, pixReq, imgX, imgY, act, eX, eY);
    end
  endtask

  task automatic runRaster(int w, int hgt, bit drop, int cycles, string tag);
    @(negedge clk);
    imgWidth = IW'(w); imgHeight = IW'(hgt); dropMode = drop;
    curW = (w == 0) ? 1 : w; curH = (hgt == 0) ? 1 : hgt;  // R10
    enable = 1'b1;
    for (int p = 1; p <= cycles; p++) begin
      @(posedge clk); @(negedge clk);
      checkOut((p >= 4) ? p - 4 : -1, tag);
      checkReq((p >= 3) ? p - 3 : -1, tag);
    end
    enable = 1'b0;
    repeat (4) @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      checkOut(-1, "R8 idle");
      checkReq(-1, "R8 idle");
    end
  endtask

  initial begin
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); @(negedge clk);
      if (k >= 1) begin checkOut(-1, "R9 reset"); checkReq(-1, "R9 reset"); end
    end
    rst = 1'b0;
    runRaster(8, 5, 1'b0, 2 * HT * VT + 6, "R1 R2 R3 R4 R5 R6 R7 full image");
    runRaster(3, 2, 1'b1, 200, "R6 R7 R8 tiled with gaps, stopped mid-frame");
    runRaster(5, 7, 1'b0, HT * VT + 20, "R1 R6 restart after stop, tall image");
    runRaster(0, 0, 1'b1, HT * VT + 4, "R10 zero size");
    runRaster(2, 3, 1'b0, HT * VT + 4, "R6 small tile");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #4000000;
    misses++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule